// File: doc/BRIEF.md
# External Interrupt Request Detector

This block watches a set of external interrupt request pins (two by default) and holds one request flag per pin for a downstream interrupt controller. Each pin has a sense-type bit. With the bit at 0, a low level on the pin raises the flag. With the bit at 1, a falling edge on the pin raises the flag. Every pin passes through a two-flop synchronizer before it is sensed. An edge is seen when one synchronized sample is 1 and the next one is 0.

The clearing rule depends on the sense type. The controller returns a one-cycle acknowledge pulse for each channel when it services that request. In falling-edge mode the acknowledge clears the flag. In low-level mode the acknowledge is ignored, and the flag stays set until software clears it.

Software uses a small register port with two selectable words: one holds the sense-type bits and one holds the request flags. Writing the flag word sets or clears flags directly, so software can raise a request of its own. A hardware set condition that arrives in the same cycle as a clearing acknowledge or a clearing write always wins, so no event is lost.

Top module: `xirq_detect`

## Requirements
- R1: After reset, every request flag is 0 and every sense-type bit is 0 (low-level mode). Reading either register word returns 0.
- R2: In low-level mode, a pin held low is first sampled at clock edge k. Its flag reads 1 after edge k+2, and the flag is set again on every cycle in which the synchronized pin is low.
- R3: In falling-edge mode, a 1-to-0 change of the synchronized pin sets the flag after edge k+2, where k is the edge that first samples the low pin. A pin that stays low does not set the flag again once it has been cleared.
- R4: In falling-edge mode, an acknowledge pulse on a channel (ack_i bit c) clears that channel's flag on the next edge, unless a set condition is present in the same cycle.
- R5: In low-level mode, an acknowledge pulse has no effect on the flag.
- R6: A register write with reg_sel_i=1 loads the flag word: bit c of reg_wdata_i sets (1) or clears (0) the flag of channel c. This applies in both modes.
- R7: A hardware set condition in the same cycle as a clearing acknowledge or a clearing flag write leaves the flag at 1.
- R8: Channels are independent: the pin, acknowledge and sense type of one channel never change another channel's flag.
- R9: A register write with reg_sel_i=0 loads the sense-type word, where bit c=1 selects falling-edge mode for channel c. reg_rdata_o returns the word chosen by reg_sel_i in the same cycle. The flags drive irq_o directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | N_CH | Asynchronous external request pins |
| ack_i | input | N_CH | Per-channel service acknowledge pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register word select: 0 = sense types, 1 = flags |
| reg_wdata_i | input | N_CH | Register write data |
| reg_rdata_o | output | N_CH | Register read data for the selected word |
| irq_o | output | N_CH | Request flags to the interrupt controller |

## Verification
The two functions that can meet in one cycle are a hardware set (a new falling edge, or a low level) and a clear (an acknowledge in falling-edge mode, or a software flag write of 0). The bench provokes this in two ways. First, it drives a falling edge on a channel whose flag is already set and times the acknowledge so that it lands on the edge where the set condition is active. Second, it runs a long random phase that mixes pin toggles, acknowledges and flag writes. A behavioural model in the bench holds a queue of past pin samples and computes the expected flags on every clock. The flag is expected to stay at 1 whenever the set coincides with a clear.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  typedef enum logic {
    SENSE_LEVEL = 1'b0,
    SENSE_FALL  = 1'b1
  } sense_e;

  typedef enum logic {
    SEL_SENSE = 1'b0,
    SEL_FLAG  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= RST_VAL;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/xirq_chan.sv
module xirq_chan #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic sense_i,
  input  logic ack_i,
  input  logic wr_i,
  input  logic wdata_i,
  output logic flag_o
);
  import xirq_pkg::*;

  logic sync_w;
  logic prev_q;
  logic set_w;
  logic flag_q;
  logic flag_d;

  xirq_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (sync_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_w;
  end

  always_comb begin
    if (sense_e'(sense_i) == SENSE_FALL) set_w = prev_q & ~sync_w;
    else                                 set_w = ~sync_w;
  end

  // hardware set dominates any clear in the same cycle
  always_comb begin
    flag_d = flag_q;
    if (wr_i)                                         flag_d = wdata_i;
    else if (ack_i && sense_e'(sense_i) == SENSE_FALL) flag_d = 1'b0;
    flag_d = flag_d | set_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  // R7
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_w |=> flag_q);

  // R5
  level_ack_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sense_i && ack_i && !wr_i && flag_q) |=> flag_q);

  // R4
  fall_ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_i && ack_i && !wr_i && !set_w) |=> !flag_q);

  // R3
  fall_rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(flag_q) && !$past(wr_i) && $past(sense_i)) |-> $past(prev_q && !sync_w));
endmodule

// File: rtl/xirq_detect.sv
module xirq_detect #(
  parameter int unsigned N_CH        = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] pin_i,
  input  logic [N_CH-1:0] ack_i,
  input  logic            reg_we_i,
  input  logic            reg_sel_i,
  input  logic [N_CH-1:0] reg_wdata_i,
  output logic [N_CH-1:0] reg_rdata_o,
  output logic [N_CH-1:0] irq_o
);
  import xirq_pkg::*;

  logic [N_CH-1:0] sense_q;
  logic [N_CH-1:0] flag_w;
  logic            wr_sense_w;
  logic            wr_flag_w;

  assign wr_sense_w = reg_we_i && reg_sel_e'(reg_sel_i) == SEL_SENSE;
  assign wr_flag_w  = reg_we_i && reg_sel_e'(reg_sel_i) == SEL_FLAG;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sense_q <= '0;
    else if (wr_sense_w) sense_q <= reg_wdata_i;
  end

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      xirq_chan #(
        .SYNC_STAGES (SYNC_STAGES)
      ) u_chan (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pin_i   (pin_i[c]),
        .sense_i (sense_q[c]),
        .ack_i   (ack_i[c]),
        .wr_i    (wr_flag_w),
        .wdata_i (reg_wdata_i[c]),
        .flag_o  (flag_w[c])
      );
    end
  endgenerate

  assign irq_o       = flag_w;
  assign reg_rdata_o = reg_sel_e'(reg_sel_i) == SEL_FLAG ? flag_w : sense_q;

  // R9
  sense_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sense_w |=> sense_q == $past(reg_wdata_i));

  // R6
  flag_write_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_flag_w |=> ((irq_o & $past(reg_wdata_i)) == $past(reg_wdata_i)));
endmodule

// File: tb/xirq_detect_tb.sv
module xirq_detect_tb_top;
  localparam int N = 2;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] pin_i = '1;
  logic [N-1:0] ack_i = '0;
  logic         reg_we_i = 1'b0;
  logic         reg_sel_i = 1'b0;
  logic [N-1:0] reg_wdata_i = '0;
  logic [N-1:0] reg_rdata_o;
  logic [N-1:0] irq_o;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";

  xirq_detect #(.N_CH(N), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .ack_i(ack_i),
    .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  always #10 clk_i = ~clk_i;

  // behavioural reference: queue of past pin samples, newest first
  logic [N-1:0] hist[$];
  logic [N-1:0] m_flag = '0;
  logic [N-1:0] m_type = '0;

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  initial begin
    for (int i = 0; i < 3; i++) hist.push_front('1);
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_flag = '0;
      m_type = '0;
      hist.delete();
      for (int i = 0; i < 3; i++) hist.push_front('1);
    end else begin
      logic [N-1:0] snc, prv, nf;
      snc = hist[1];
      prv = hist[2];
      for (int c = 0; c < N; c++) begin
        logic st;
        st = m_type[c] ? (prv[c] & ~snc[c]) : ~snc[c];
        if (reg_we_i && reg_sel_i)        nf[c] = reg_wdata_i[c];
        else if (ack_i[c] && m_type[c])   nf[c] = 1'b0;
        else                              nf[c] = m_flag[c];
        nf[c] = nf[c] | st;
      end
      if (reg_we_i && !reg_sel_i) m_type = reg_wdata_i;
      m_flag = nf;
      hist.push_front(pin_i);
      void'(hist.pop_back());
    end
    #5;
    if (rst_ni) begin
      chk(cur_req, irq_o, m_flag, "irq_o vs model");
      chk(cur_req, reg_rdata_o, reg_sel_i ? m_flag : m_type, "reg_rdata_o vs model");
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic reg_write(logic sel, logic [N-1:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic ack(logic [N-1:0] m);
    @(negedge clk_i);
    ack_i = m;
    @(negedge clk_i);
    ack_i = '0;
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cyc(3);
    // R1
    chk("R1", irq_o, '0, "flags at reset");
    chk("R1", reg_rdata_o, '0, "sense word at reset");
    rst_ni = 1'b1;
    cyc(2);
    reg_sel_i = 1'b1;
    cyc(1);
    chk("R1", reg_rdata_o, '0, "flag word after reset");

    // R2 level mode on channel 0
    cur_req = "R2";
    @(negedge clk_i); pin_i[0] = 1'b0;
    cyc(2);
    chk("R2", irq_o, 2'b00, "before sync latency");
    cyc(1);
    chk("R2", irq_o, 2'b01, "low level sets flag");
    // R5
    cur_req = "R5";
    ack(2'b01);
    pin_i[0] = 1'b1;
    cyc(3);
    ack(2'b01);
    cyc(1);
    chk("R5", irq_o, 2'b01, "ack ignored in level mode");
    // R6
    cur_req = "R6";
    reg_write(1'b1, 2'b00);
    chk("R6", irq_o, 2'b00, "software clear");
    reg_write(1'b1, 2'b10);
    chk("R6", irq_o, 2'b10, "software set");
    reg_write(1'b1, 2'b00);

    // R9 sense word
    cur_req = "R9";
    reg_write(1'b0, 2'b11);
    reg_sel_i = 1'b0;
    cyc(1);
    chk("R9", reg_rdata_o, 2'b11, "sense word readback");
    reg_sel_i = 1'b1;

    // R3 falling edge on channel 1, held low
    cur_req = "R3";
    @(negedge clk_i); pin_i[1] = 1'b0;
    cyc(3);
    chk("R3", irq_o, 2'b10, "falling edge sets flag");
    reg_write(1'b1, 2'b00);
    cyc(6);
    chk("R3", irq_o, 2'b00, "steady low does not re-set");
    // R4
    cur_req = "R4";
    @(negedge clk_i); pin_i[1] = 1'b1;
    cyc(3);
    @(negedge clk_i); pin_i[1] = 1'b0;
    cyc(4);
    chk("R4", irq_o, 2'b10, "second edge sets flag");
    ack(2'b10);
    chk("R4", irq_o, 2'b00, "ack clears in edge mode");

    // R7 new edge coincides with ack on channel 0
    cur_req = "R7";
    @(negedge clk_i); pin_i[0] = 1'b0;
    cyc(4);
    @(negedge clk_i); pin_i[0] = 1'b1;
    cyc(3);
    @(negedge clk_i); pin_i[0] = 1'b0;   // sampled at edge k
    @(negedge clk_i);                    // after k
    @(negedge clk_i); ack_i = 2'b01;     // active at edge k+2
    @(negedge clk_i); ack_i = '0;
    chk("R7", irq_o[0] ? 2'b01 : 2'b00, 2'b01, "edge beats ack");
    // R7 edge coincides with software clear
    @(negedge clk_i); pin_i[0] = 1'b1;
    cyc(3);
    @(negedge clk_i); pin_i[0] = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i); reg_we_i = 1'b1; reg_sel_i = 1'b1; reg_wdata_i = 2'b00;
    @(negedge clk_i); reg_we_i = 1'b0;
    chk("R7", irq_o[0] ? 2'b01 : 2'b00, 2'b01, "edge beats clear write");

    // R8 independence: mixed modes, random stimulus against model
    cur_req = "R8";
    reg_write(1'b0, 2'b01);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk_i);
      pin_i       = N'($urandom);
      ack_i       = ($urandom % 4 == 0) ? N'($urandom) : '0;
      reg_we_i    = ($urandom % 8 == 0);
      reg_sel_i   = ($urandom % 4 != 0);
      reg_wdata_i = N'($urandom);
    end
    @(negedge clk_i);
    reg_we_i = 1'b0; ack_i = '0; pin_i = '1;
    cyc(4);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule